// File: doc/BRIEF.md
# Dual Byte FIFO with Timed Flush

This block holds the two byte queues that sit between a serial-bus master's protocol engine and its register interface. The transmit queue is filled from the register side and drained by the engine. The receive queue is filled by the engine and drained from the register side. Every data path is a valid/ready stream. A beat moves on a rising clock edge only when both valid and ready are high in that cycle. A sender may hold valid high for as long as it likes. A receiver that lowers ready stalls the stream without losing data, with one exception: a transmit write offered while the queue is full is discarded and flagged as an overrun.

Each queue has a programmable threshold. The effective value is capped at half the depth minus one. The transmit side reports a nearly-empty level and the receive side reports a nearly-full level, alongside plain empty and full flags. Either queue can be flushed on its own. The flush runs for a fixed number of cycles, its busy bit reads 1 for that time, and at the end the queue is empty and the busy bit clears by itself.

Top module: `dual_byte_fifo`

## Requirements
- R1: After reset both queues are empty, neither is full, and neither flush-busy bit is set.
- R2: Bytes leave each queue in the order they were accepted: transmit goes from the host port to the engine port, and receive goes from the engine port to the host port.
- R3: A queue's input ready is high exactly when the queue holds fewer than DEPTH entries and is not flushing. Its output valid is high exactly when the queue holds at least one entry and is not flushing.
- R4: A transmit write offered (host_tx_valid high) while the transmit queue is full and not flushing raises tx_overrun in that same cycle, and the byte is dropped.
- R5: Each threshold in use is the smaller of the programmed value and DEPTH/2-1, which is 7 for DEPTH 16 and 15 for DEPTH 32.
- R6: tx_nearly_empty is high when the transmit entry count is less than or equal to the effective transmit threshold.
- R7: rx_nearly_full is high when the receive entry count is greater than or equal to the effective receive threshold.
- R8: A flush request seen while the queue is idle sets its busy bit for exactly 4 cycles. The busy bit then clears, and in that same cycle the queue is empty. A request made while busy is ignored.
- R9: While a queue is flushing, neither pushes nor pops change its contents.
- R10: With the receive queue empty, host_rx_data is 0x00, and a read attempt leaves the pointers where they were, so the next byte written arrives intact.
- R11: Flushing one queue leaves the other queue's contents and traffic untouched.
- R12: A queue's full flag is high at DEPTH entries and its empty flag is high at zero entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_level_set | input | THR_W | Programmed transmit threshold |
| rx_level_set | input | THR_W | Programmed receive threshold |
| tx_flush_req | input | 1 | Start a transmit flush |
| rx_flush_req | input | 1 | Start a receive flush |
| tx_flush_busy | output | 1 | Transmit flush in progress |
| rx_flush_busy | output | 1 | Receive flush in progress |
| host_tx_valid | input | 1 | Host offers a transmit byte |
| host_tx_ready | output | 1 | Transmit queue accepts a byte |
| host_tx_data | input | DW | Transmit byte from host |
| eng_tx_valid | output | 1 | Transmit byte available to engine |
| eng_tx_ready | input | 1 | Engine takes the transmit byte |
| eng_tx_data | output | DW | Transmit byte to engine |
| eng_rx_valid | input | 1 | Engine offers a received byte |
| eng_rx_ready | output | 1 | Receive queue accepts a byte |
| eng_rx_data | input | DW | Received byte from engine |
| host_rx_valid | output | 1 | Received byte available to host |
| host_rx_ready | input | 1 | Host takes the received byte |
| host_rx_data | output | DW | Received byte to host, 0x00 when empty |
| tx_empty | output | 1 | Transmit queue empty |
| tx_nearly_empty | output | 1 | Transmit count at or below threshold |
| tx_full | output | 1 | Transmit queue full |
| tx_overrun | output | 1 | Write offered to full transmit queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_nearly_full | output | 1 | Receive count at or above threshold |
| rx_full | output | 1 | Receive queue full |

## Verification
Long random runs, with independent push, pop and flush activity on both queues, confirm that byte order and the level flags stay right while stalls, simultaneous push and pop, and flushes interleave. A directed fill past full separates a dropped overrun byte from a stored one, since the drained sequence must not contain it. Thresholds programmed above the cap show whether clamping happens, because the nearly flags would move at a different count without it. A read from the empty receive queue followed by a single write shows whether the empty read moved a pointer, because a moved pointer would return a stale byte.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
  localparam int FLUSH_CYCLES = 4;

  function automatic int thr_cap(input int depth);
    return depth / 2 - 1;
  endfunction
endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
endmodule

// File: rtl/flush_timer.sv
module flush_timer #(
  parameter int CYCLES = fifo_pair_pkg::FLUSH_CYCLES,
  localparam int TW    = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic busy,
  output logic done
);
  logic [TW-1:0] tick;

  assign done = busy && (tick == TW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tick <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      tick <= done ? '0 : tick + 1'b1;
    end else if (req) begin
      busy <= 1'b1;
      tick <= '0;
    end
  end
endmodule

// File: rtl/level_compare.sv
module level_compare #(
  parameter int DEPTH    = 16,
  parameter int THR_W    = 8,
  parameter bit AT_MOST  = 1'b1,
  localparam int CW      = $clog2(DEPTH) + 1,
  localparam int CAP     = fifo_pair_pkg::thr_cap(DEPTH)
) (
  input  logic [THR_W-1:0] thr_set,
  input  logic [CW-1:0]    count,
  output logic             hit
);
  logic [31:0] thr_eff, cnt_w;

  assign thr_eff = (32'(thr_set) > 32'(CAP)) ? 32'(CAP) : 32'(thr_set);
  assign cnt_w   = 32'(count);

  generate
    if (AT_MOST) begin : g_low
      assign hit = (cnt_w <= thr_eff);
    end else begin : g_high
      assign hit = (cnt_w >= thr_eff);
    end
  endgenerate
endmodule

// File: rtl/dual_byte_fifo.sv
module dual_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int THR_W = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [THR_W-1:0] tx_level_set,
  input  logic [THR_W-1:0] rx_level_set,
  input  logic             tx_flush_req,
  input  logic             rx_flush_req,
  output logic             tx_flush_busy,
  output logic             rx_flush_busy,
  input  logic             host_tx_valid,
  output logic             host_tx_ready,
  input  logic [DW-1:0]    host_tx_data,
  output logic             eng_tx_valid,
  input  logic             eng_tx_ready,
  output logic [DW-1:0]    eng_tx_data,
  input  logic             eng_rx_valid,
  output logic             eng_rx_ready,
  input  logic [DW-1:0]    eng_rx_data,
  output logic             host_rx_valid,
  input  logic             host_rx_ready,
  output logic [DW-1:0]    host_rx_data,
  output logic             tx_empty,
  output logic             tx_nearly_empty,
  output logic             tx_full,
  output logic             tx_overrun,
  output logic             rx_empty,
  output logic             rx_nearly_full,
  output logic             rx_full
);
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_done, rx_done;
  logic [DW-1:0] rx_head;

  // transmit lane
  flush_timer u_tx_flush (
    .clk(clk), .rst_n(rst_n), .req(tx_flush_req), .busy(tx_flush_busy), .done(tx_done)
  );

  assign tx_empty      = (tx_cnt == '0);
  assign tx_full       = (tx_cnt == CW'(DEPTH));
  assign host_tx_ready = !tx_full && !tx_flush_busy;
  assign eng_tx_valid  = !tx_empty && !tx_flush_busy;
  assign tx_overrun    = host_tx_valid && tx_full && !tx_flush_busy;

  fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_tx_store (
    .clk(clk), .rst_n(rst_n), .clear(tx_done),
    .push(host_tx_valid && host_tx_ready), .push_data(host_tx_data),
    .pop(eng_tx_valid && eng_tx_ready), .head_data(eng_tx_data), .count(tx_cnt)
  );

  level_compare #(.DEPTH(DEPTH), .THR_W(THR_W), .AT_MOST(1'b1)) u_tx_level (
    .thr_set(tx_level_set), .count(tx_cnt), .hit(tx_nearly_empty)
  );

  // receive lane
  flush_timer u_rx_flush (
    .clk(clk), .rst_n(rst_n), .req(rx_flush_req), .busy(rx_flush_busy), .done(rx_done)
  );

  assign rx_empty      = (rx_cnt == '0);
  assign rx_full       = (rx_cnt == CW'(DEPTH));
  assign eng_rx_ready  = !rx_full && !rx_flush_busy;
  assign host_rx_valid = !rx_empty && !rx_flush_busy;
  assign host_rx_data  = rx_empty ? '0 : rx_head;

  fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_rx_store (
    .clk(clk), .rst_n(rst_n), .clear(rx_done),
    .push(eng_rx_valid && eng_rx_ready), .push_data(eng_rx_data),
    .pop(host_rx_valid && host_rx_ready), .head_data(rx_head), .count(rx_cnt)
  );

  level_compare #(.DEPTH(DEPTH), .THR_W(THR_W), .AT_MOST(1'b0)) u_rx_level (
    .thr_set(rx_level_set), .count(rx_cnt), .hit(rx_nearly_full)
  );
endmodule

// File: rtl/fifo_pair_chk.sv
module fifo_pair_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_flush_busy,
  input logic          rx_flush_busy,
  input logic          host_tx_ready,
  input logic          eng_tx_valid,
  input logic          eng_rx_ready,
  input logic          host_rx_valid,
  input logic [DW-1:0] host_rx_data,
  input logic          tx_empty,
  input logic          tx_full,
  input logic          tx_overrun,
  input logic          rx_empty,
  input logic          rx_full
);
  // R8
  tx_flush_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_flush_busy) |-> tx_flush_busy ##1 tx_flush_busy ##1 tx_flush_busy ##1 tx_flush_busy ##1 !tx_flush_busy);
  // R8
  tx_flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_flush_busy) |-> tx_empty);
  // R8
  rx_flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_flush_busy) |-> rx_empty);
  // R9
  tx_flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush_busy && $past(tx_flush_busy)) |-> ($stable(tx_empty) && $stable(tx_full)));
  // R9
  rx_flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flush_busy && $past(rx_flush_busy)) |-> ($stable(rx_empty) && $stable(rx_full)));
  // R3
  flush_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush_busy |-> (!host_tx_ready && !eng_tx_valid)) and
    (rx_flush_busy |-> (!eng_rx_ready && !host_rx_valid)));
  // R4
  overrun_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overrun |-> (tx_full && !host_tx_ready));
  // R10
  rx_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> (host_rx_data == '0 && !host_rx_valid));
  // R12
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty) && !(rx_full && rx_empty));
endmodule

bind dual_byte_fifo fifo_pair_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .tx_flush_busy(tx_flush_busy), .rx_flush_busy(rx_flush_busy),
  .host_tx_ready(host_tx_ready), .eng_tx_valid(eng_tx_valid),
  .eng_rx_ready(eng_rx_ready), .host_rx_valid(host_rx_valid),
  .host_rx_data(host_rx_data),
  .tx_empty(tx_empty), .tx_full(tx_full), .tx_overrun(tx_overrun),
  .rx_empty(rx_empty), .rx_full(rx_full)
);

// File: tb/dual_byte_fifo_tb.sv
module dual_byte_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 16;
  localparam int DW = 8;
  localparam int TW = 8;
  localparam int CAP = D / 2 - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] tx_level_set = '0, rx_level_set = '0;
  logic tx_flush_req = 0, rx_flush_req = 0;
  logic tx_flush_busy, rx_flush_busy;
  logic host_tx_valid = 0, eng_tx_ready = 0, eng_rx_valid = 0, host_rx_ready = 0;
  logic [DW-1:0] host_tx_data = '0, eng_rx_data = '0;
  logic host_tx_ready, eng_tx_valid, eng_rx_ready, host_rx_valid;
  logic [DW-1:0] eng_tx_data, host_rx_data;
  logic tx_empty, tx_nearly_empty, tx_full, tx_overrun;
  logic rx_empty, rx_nearly_full, rx_full;

  int vectors = 0;
  int miscompares = 0;

  logic [DW-1:0] mq_tx[$];
  logic [DW-1:0] mq_rx[$];
  bit tb_busy = 0, rb_busy = 0;
  int tb_cnt = 0, rb_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_byte_fifo #(.DEPTH(D), .DW(DW), .THR_W(TW)) dut_i (.*);

  function automatic int eff_thr(input logic [TW-1:0] t);
    return (int'(t) > CAP) ? CAP : int'(t);
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic step();
    int ts, rs;
    bit tx_push, tx_pop, rx_push, rx_pop;
    #1;
    ts = mq_tx.size(); rs = mq_rx.size();
    chk("R12", 32'(tx_empty), 32'(ts == 0));
    chk("R12", 32'(tx_full), 32'(ts == D));
    chk("R3", 32'(host_tx_ready), 32'(ts < D && !tb_busy));
    chk("R3", 32'(eng_tx_valid), 32'(ts > 0 && !tb_busy));
    if (ts > 0 && !tb_busy) chk("R2", 32'(eng_tx_data), 32'(mq_tx[0]));
    chk("R4", 32'(tx_overrun), 32'(host_tx_valid && ts == D && !tb_busy));
    chk("R6", 32'(tx_nearly_empty), 32'(ts <= eff_thr(tx_level_set)));
    chk("R8", 32'(tx_flush_busy), 32'(tb_busy));
    chk("R12", 32'(rx_empty), 32'(rs == 0));
    chk("R12", 32'(rx_full), 32'(rs == D));
    chk("R3", 32'(eng_rx_ready), 32'(rs < D && !rb_busy));
    chk("R3", 32'(host_rx_valid), 32'(rs > 0 && !rb_busy));
    if (rs > 0 && !rb_busy) chk("R2", 32'(host_rx_data), 32'(mq_rx[0]));
    if (rs == 0) chk("R10", 32'(host_rx_data), 32'h0);
    chk("R7", 32'(rx_nearly_full), 32'(rs >= eff_thr(rx_level_set)));
    chk("R8", 32'(rx_flush_busy), 32'(rb_busy));
    tx_push = host_tx_valid && ts < D && !tb_busy;
    tx_pop  = eng_tx_ready && ts > 0 && !tb_busy;
    rx_push = eng_rx_valid && rs < D && !rb_busy;
    rx_pop  = host_rx_ready && rs > 0 && !rb_busy;
    @(posedge clk);
    // R9: model applies no push/pop while busy
    if (tb_busy) begin
      if (tb_cnt == 3) begin tb_busy = 0; mq_tx.delete(); end else tb_cnt++;
    end else begin
      if (tx_pop) void'(mq_tx.pop_front());
      if (tx_push) mq_tx.push_back(host_tx_data);
      if (tx_flush_req) begin tb_busy = 1; tb_cnt = 0; end
    end
    if (rb_busy) begin
      if (rb_cnt == 3) begin rb_busy = 0; mq_rx.delete(); end else rb_cnt++;
    end else begin
      if (rx_pop) void'(mq_rx.pop_front());
      if (rx_push) mq_rx.push_back(eng_rx_data);
      if (rx_flush_req) begin rb_busy = 1; rb_cnt = 0; end
    end
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    host_tx_valid = 0; eng_tx_ready = 0; eng_rx_valid = 0; host_rx_ready = 0;
    tx_flush_req = 0; rx_flush_req = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", {26'h0, tx_empty, rx_empty, tx_full, rx_full, tx_flush_busy, rx_flush_busy}, 32'b110000);

    // R5 clamp: thresholds far above the cap
    tx_level_set = 8'd200; rx_level_set = 8'd200;
    for (int i = 0; i < CAP; i++) begin
      host_tx_valid = 1; host_tx_data = 8'(8'h10 + i);
      eng_rx_valid = 1; eng_rx_data = 8'(8'h80 + i);
      step();
    end
    idle_inputs();
    #1;
    chk("R5", 32'(tx_nearly_empty), 32'd1);
    chk("R5", 32'(rx_nearly_full), 32'd1);
    host_tx_valid = 1; host_tx_data = 8'h17;
    step();
    #1;
    chk("R5", 32'(tx_nearly_empty), 32'd0);

    // fill to full, then overrun with a marker byte (R4, R12)
    for (int i = CAP + 1; i < D; i++) begin
      host_tx_data = 8'(8'h10 + i);
      step();
    end
    host_tx_data = 8'hEE;
    step();
    step();
    host_tx_valid = 0;
    eng_tx_ready = 1;
    for (int i = 0; i < D; i++) begin
      #1;
      chk("R4", 32'(eng_tx_data), 32'(8'h10 + i));
      step();
    end
    eng_tx_ready = 0;

    // R10: drain rx, read empty, then one write returns intact
    host_rx_ready = 1;
    for (int i = 0; i < CAP + 2; i++) step();
    #1;
    chk("R10", 32'(host_rx_data), 32'h0);
    host_rx_ready = 0;
    eng_rx_valid = 1; eng_rx_data = 8'h5A;
    step();
    eng_rx_valid = 0;
    #1;
    chk("R10", 32'(host_rx_data), 32'h5A);

    // R9 / R11: tx flush with traffic offered on both queues
    host_tx_valid = 1; host_tx_data = 8'h33;
    step(); step();
    tx_flush_req = 1;
    step();
    tx_flush_req = 0;
    eng_tx_ready = 1; eng_rx_valid = 1; eng_rx_data = 8'h6B;
    for (int i = 0; i < 4; i++) step();
    idle_inputs();
    #1;
    chk("R9", 32'(tx_empty), 32'd1);
    chk("R11", 32'(rx_empty), 32'd0);
    chk("R11", 32'(host_rx_data), 32'h5A);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      host_tx_valid = ($urandom_range(0, 9) < 6);
      host_tx_data  = 8'($urandom);
      eng_tx_ready  = ($urandom_range(0, 9) < 4);
      eng_rx_valid  = ($urandom_range(0, 9) < 5);
      eng_rx_data   = 8'($urandom);
      host_rx_ready = ($urandom_range(0, 9) < 5);
      tx_flush_req  = ($urandom_range(0, 99) < 2);
      rx_flush_req  = ($urandom_range(0, 99) < 2);
      if ($urandom_range(0, 49) == 0) tx_level_set = 8'($urandom_range(0, 20));
      if ($urandom_range(0, 49) == 0) rx_level_set = 8'($urandom_range(0, 20));
      step();
    end
    idle_inputs();
    step();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule